// File: doc/BRIEF.md
# Run-Length and Pseudo-Random Test Pattern Expander

This block turns compact test records into a stream of per-cycle stimulus for a core under test. A record arrives on a valid/ready handshake. It carries a one-bit type, a pattern or seed word, a polynomial word and a 16-bit count.

A deterministic record stands for a run of identical patterns that was stored once. The block drives that pattern for the given number of accepted output transfers. A pseudo-random record holds a seed, a feedback polynomial and a count. The block emits the seed first and then advances a Galois shift register once for each later pattern. Both kinds of record share one output stream, which also uses a valid/ready handshake.

A one-cycle done flag marks the transfer that ends each record. The next record is taken only after that transfer has completed.

Top module: `pe_expander`

## Requirements
- R1: While reset is held and directly after it, `rec_ready_o` is 1, `stim_valid_o` is 0 and `done_o` is 0.
- R2: A record with type bit 0 (deterministic) places `rec_pattern_i` on `stim_data_o` for exactly N accepted output transfers, where N is `rec_count_i`, and the value does not change between those transfers.
- R3: A count of zero behaves as a count of one, so the record produces exactly one output transfer.
- R4: A record with type bit 1 (pseudo-random) first emits `rec_pattern_i` as the seed. Each later pattern is `(s >> 1) ^ (s[0] ? rec_poly_i : 0)`, where s is the previous pattern. The record emits N patterns in total.
- R5: `rec_ready_o` stays 0 from the cycle after a record is accepted until the last pattern of that record has been taken. A new record is accepted only while `rec_ready_o` is 1.
- R6: `done_o` is 1 only in the cycle in which the final pattern of a record is transferred, meaning `stim_valid_o` and `stim_ready_i` are both 1.
- R7: While `stim_valid_o` is 1 and `stim_ready_i` is 0, the next cycle keeps `stim_valid_o` at 1 with `stim_data_o` unchanged, and the remaining count does not advance.
- R8: In a deterministic record the polynomial field has no effect. The pattern stays constant whatever `rec_poly_i` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rec_valid_i | input | 1 | Record offered |
| rec_ready_o | output | 1 | Block can accept a record |
| rec_type_i | input | 1 | 0 deterministic, 1 pseudo-random |
| rec_pattern_i | input | PAT_W (16) | Pattern or seed |
| rec_poly_i | input | PAT_W (16) | Feedback polynomial (pseudo-random only) |
| rec_count_i | input | CNT_W (16) | Pattern count, 0 read as 1 |
| stim_valid_o | output | 1 | Stimulus word valid |
| stim_ready_i | input | 1 | Core side takes the word |
| stim_data_o | output | PAT_W (16) | Stimulus word |
| done_o | output | 1 | Final transfer of the current record |

## Verification
The stimulus covers several cases that each separate one kind of fault:
- Deterministic runs of length three and four show whether the repeat count is off by one.
- A record with a zero count separates the zero-as-one rule from a counter that wraps.
- Two pseudo-random records, one seeded with 1 and one with a dense seed, expose a wrong shift direction or a feedback tap applied when the low bit is 0.
- A deterministic record with an all-ones polynomial shows whether the polynomial leaks into the deterministic path.
- Runs with a periodic stall on the output, and records offered back to back, check that the data holds under backpressure and that no record is accepted early.

// File: rtl/pe_pkg.sv
package pe_pkg;
  typedef enum logic {
    REC_DET  = 1'b0,
    REC_LFSR = 1'b1
  } rec_kind_e;
endpackage

// File: rtl/pe_run_counter.sv
module pe_run_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             step_i,
  output logic             last_o
);
  logic [CNT_W-1:0] remain_q;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      remain_q <= ONE;
    end else if (load_i) begin
      // zero count still yields one pattern
      remain_q <= (count_i == '0) ? ONE : count_i;
    end else if (step_i && !last_o) begin
      remain_q <= remain_q - ONE;
    end
  end

  assign last_o = (remain_q == ONE);
endmodule

// File: rtl/pe_pattern_src.sv
module pe_pattern_src
  import pe_pkg::*;
#(
  parameter int PAT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  rec_kind_e        kind_i,
  input  logic [PAT_W-1:0] seed_i,
  input  logic [PAT_W-1:0] poly_i,
  input  logic             step_i,
  output logic [PAT_W-1:0] data_o
);
  logic [PAT_W-1:0] pat_q, poly_q, pat_next;
  rec_kind_e        kind_q;

  // Galois step, shifting toward bit 0
  always_comb begin
    pat_next = {1'b0, pat_q[PAT_W-1:1]};
    if (pat_q[0]) pat_next = pat_next ^ poly_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pat_q  <= '0;
      poly_q <= '0;
      kind_q <= REC_DET;
    end else if (load_i) begin
      pat_q  <= seed_i;
      poly_q <= poly_i;
      kind_q <= kind_i;
    end else if (step_i && kind_q == REC_LFSR) begin
      pat_q <= pat_next;
    end
  end

  assign data_o = pat_q;
endmodule

// File: rtl/pe_expander.sv
module pe_expander
  import pe_pkg::*;
#(
  parameter int PAT_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rec_valid_i,
  output logic             rec_ready_o,
  input  logic             rec_type_i,
  input  logic [PAT_W-1:0] rec_pattern_i,
  input  logic [PAT_W-1:0] rec_poly_i,
  input  logic [CNT_W-1:0] rec_count_i,
  output logic             stim_valid_o,
  input  logic             stim_ready_i,
  output logic [PAT_W-1:0] stim_data_o,
  output logic             done_o
);
  logic busy_q, accept, fire, last;

  assign accept = rec_valid_i && !busy_q;
  assign fire   = busy_q && stim_ready_i;

  // fire gating also advances the source only on a real transfer
  pe_run_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .count_i(rec_count_i),
    .step_i (fire),
    .last_o (last)
  );

  pe_pattern_src #(.PAT_W(PAT_W)) u_src (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(accept),
    .kind_i(rec_kind_e'(rec_type_i)),
    .seed_i(rec_pattern_i),
    .poly_i(rec_poly_i),
    .step_i(fire),
    .data_o(stim_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            busy_q <= 1'b0;
    else if (accept)        busy_q <= 1'b1;
    else if (fire && last)  busy_q <= 1'b0;
  end

  assign rec_ready_o  = !busy_q;
  assign stim_valid_o = busy_q;
  assign done_o       = fire && last;
endmodule

// File: rtl/pe_expander_chk.sv
module pe_expander_chk #(
  parameter int PAT_W = 16,
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rec_valid_i,
  input logic             rec_ready_o,
  input logic [PAT_W-1:0] rec_pattern_i,
  input logic             stim_valid_o,
  input logic             stim_ready_i,
  input logic [PAT_W-1:0] stim_data_o,
  input logic             done_o
);
  AST_START_WITH_RECORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_valid_i && rec_ready_o) |=> (stim_valid_o && stim_data_o == $past(rec_pattern_i))); // R2

  AST_NO_EARLY_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stim_valid_o |-> !rec_ready_o); // R5

  AST_RUN_CONTINUES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stim_valid_o && stim_ready_i && !done_o) |=> stim_valid_o); // R5

  AST_DONE_ON_TRANSFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (stim_valid_o && stim_ready_i)); // R6

  AST_HOLD_ON_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stim_valid_o && !stim_ready_i) |=> (stim_valid_o && $stable(stim_data_o))); // R7

  AST_RESET_IDLE: assert property (@(posedge clk_i)
    !rst_ni |-> (!stim_valid_o && rec_ready_o && !done_o)); // R1
endmodule

bind pe_expander pe_expander_chk #(.PAT_W(PAT_W), .CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rec_valid_i  (rec_valid_i),
  .rec_ready_o  (rec_ready_o),
  .rec_pattern_i(rec_pattern_i),
  .stim_valid_o (stim_valid_o),
  .stim_ready_i (stim_ready_i),
  .stim_data_o  (stim_data_o),
  .done_o       (done_o)
);

// File: tb/sim_pe_expander.sv
`timescale 1ns/1ps
module sim_pe_expander;
  logic        clk_i = 0, rst_ni = 0;
  logic        rec_valid_i = 0, rec_type_i = 0, stim_ready_i = 0;
  logic [15:0] rec_pattern_i = 0, rec_poly_i = 0, rec_count_i = 0;
  logic        rec_ready_o, stim_valid_o, done_o;
  logic [15:0] stim_data_o;

  pe_expander u0 (.*);

  always #4 clk_i = ~clk_i;

  int checks = 0, failures = 0, cyc = 0, n_out = 0;
  bit stall_mode = 0, m_busy = 0, m_lfsr = 0;
  logic [15:0] mq[$];
  string data_tag = "R2";

  function automatic logic [15:0] nxt(logic [15:0] s, logic [15:0] p);
    logic [15:0] r = s >> 1;
    if (s[0]) r = r ^ p;
    return r;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference model
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_busy = 0; mq.delete();
    end else if (!m_busy) begin
      if (rec_valid_i) begin
        logic [15:0] s;
        int n;
        n = (rec_count_i == 0) ? 1 : int'(rec_count_i);
        s = rec_pattern_i;
        m_lfsr = rec_type_i;
        for (int i = 0; i < n; i++) begin
          mq.push_back(s);
          if (rec_type_i) s = nxt(s, rec_poly_i);
        end
        m_busy = 1;
      end
    end else if (stim_ready_i) begin
      void'(mq.pop_front());
      n_out++;
      if (mq.size() == 0) m_busy = 0;
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    #1 stim_ready_i <= stall_mode ? (cyc % 3 != 0) : 1'b1;
  end

  logic        pv = 0, pr = 0;
  logic [15:0] pd = 0;
  always @(negedge clk_i) if (rst_ni) begin
    chk(stim_valid_o == m_busy, "R2", "stim_valid", stim_valid_o, m_busy);
    chk(rec_ready_o == !m_busy, "R5", "rec_ready", rec_ready_o, !m_busy);
    chk(done_o == (m_busy && stim_ready_i && mq.size() == 1), "R6", "done",
        done_o, m_busy && stim_ready_i && mq.size() == 1);
    if (m_busy)
      chk(stim_data_o == mq[0], m_lfsr ? "R4" : data_tag, "data", stim_data_o, mq[0]);
    if (pv && !pr && m_busy)
      chk(stim_data_o == pd, "R7", "stall hold", stim_data_o, pd);
    pv = stim_valid_o; pr = stim_ready_i; pd = stim_data_o;
  end

  task automatic send(bit t, logic [15:0] p, logic [15:0] poly, logic [15:0] c);
    @(posedge clk_i); #1;
    rec_valid_i = 1; rec_type_i = t; rec_pattern_i = p; rec_poly_i = poly; rec_count_i = c;
    while (!rec_ready_o) begin @(posedge clk_i); #1; end
    @(posedge clk_i); #1;
    rec_valid_i = 0;
  endtask

  task automatic drain();
    while (m_busy || stim_valid_o) @(posedge clk_i);
    repeat (2) @(posedge clk_i);
  endtask

  initial begin
    #3;
    chk(rec_ready_o == 1, "R1", "reset rec_ready", rec_ready_o, 1);
    chk(stim_valid_o == 0, "R1", "reset stim_valid", stim_valid_o, 0);
    chk(done_o == 0, "R1", "reset done", done_o, 0);
    #20 rst_ni = 1;
    // R2 run of three
    send(0, 16'hA5C3, 16'h0, 3); drain();
    // R3 zero count
    n_out = 0; send(0, 16'h1234, 16'h0, 0); drain();
    chk(n_out == 1, "R3", "zero-count transfers", n_out, 1);
    // R4 seed of one
    n_out = 0; send(1, 16'h0001, 16'hB400, 6); drain();
    chk(n_out == 6, "R4", "lfsr transfers", n_out, 6);
    // R7 with stalls
    stall_mode = 1;
    n_out = 0; send(0, 16'h0F0F, 16'h0, 4); drain();
    chk(n_out == 4, "R2", "run length under stall", n_out, 4);
    send(1, 16'hACE1, 16'hB400, 7); drain();
    // R5 back to back
    send(0, 16'h5555, 16'h0, 2);
    send(1, 16'h8001, 16'hD008, 3);
    drain();
    // R8 poly ignored for deterministic
    data_tag = "R8"; stall_mode = 0;
    n_out = 0; send(0, 16'h3C3C, 16'hFFFF, 3); drain();
    chk(n_out == 3, "R8", "det transfers with poly", n_out, 3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule